// File: doc/BRIEF.md
# Texture binding pointer resolver

This block turns a 13-bit word index carried by a texture instruction into the pair of pointers a texture unit needs: a header pointer and a sampler pointer. It reads one 32-bit packed binding word from a constant bank over a request/response port with variable latency. The bank number comes from externally held state, not from the instruction. The word is split into a 20-bit header field in bits [19:0] and a 12-bit sampler field in bits [31:20].

A binding-mode bit can make the header pointer serve as the sampler pointer as well. Both effective pointers are then compared against programmable maximum indices. A pointer above its limit does not raise an error. Instead it flags the access as an invalid-texture access through a separate output.

Only one lookup is in flight at a time. A lookup is launched by a start pulse and closed by a one-cycle done pulse. The result stays on the outputs until the next lookup completes.

Top module: `tex_bind_resolver`

## Requirements
- R1: After reset, req_valid_o, done_o, invalid_o, hdr_ptr_o and smp_ptr_o are all 0.
- R2: In the cycle after an accepted start, req_valid_o is 1, with req_addr_o equal to the captured index and req_bank_o equal to the captured bank select. These three stay stable until a clock edge that sees req_ready_i high, and req_valid_o is 0 in the following cycle.
- R3: hdr_ptr_o equals bits [19:0] of the returned word. When hdr_bind_mode_i was 0 at start, smp_ptr_o equals bits [31:20] of the word, zero-extended to 20 bits.
- R4: When hdr_bind_mode_i was 1 at start, smp_ptr_o equals hdr_ptr_o, and bits [31:20] of the word have no effect.
- R5: invalid_o is 1 exactly when hdr_ptr_o exceeds the captured header limit, or smp_ptr_o (the effective sampler pointer, after mode substitution) exceeds the captured sampler limit. Both comparisons are unsigned and strictly greater-than, so a pointer equal to its limit is valid.
- R6: done_o is 1 for exactly one cycle: the cycle after the edge at which rsp_valid_i is sampled high while a response is awaited. The pointer and invalid outputs hold their values until the next done pulse.
- R7: start_i has no effect from the cycle after an accepted start through the done cycle. rsp_valid_i has no effect unless a response is awaited.
- R8: The index, bank select, mode bit and both limits are captured at the accepted start. Changes to them afterwards do not affect the running lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a lookup (taken when idle) |
| index_i | input | 13 | Word index into the constant bank |
| bank_sel_i | input | 5 | Constant bank number from external state |
| hdr_bind_mode_i | input | 1 | 1: header pointer also used as sampler pointer |
| max_hdr_idx_i | input | 20 | Largest valid header pointer |
| max_smp_idx_i | input | 20 | Largest valid sampler pointer |
| req_valid_o | output | 1 | Constant bank read request |
| req_ready_i | input | 1 | Request accepted by the bank |
| req_bank_o | output | 5 | Bank number of the request |
| req_addr_o | output | 13 | Word address of the request |
| rsp_valid_i | input | 1 | Read data returned |
| rsp_data_i | input | 32 | Packed binding word |
| done_o | output | 1 | One-cycle lookup completion pulse |
| hdr_ptr_o | output | 20 | Header pointer |
| smp_ptr_o | output | 20 | Effective sampler pointer |
| invalid_o | output | 1 | Invalid-texture flag |

## Verification
The bench places limits exactly at a pointer value and one below it. A design using greater-or-equal, or a signed compare, would flag valid textures as invalid or miss oversized ones. In header-binding mode it returns words with a large upper field, so a design that checked the raw sampler field, or passed it out, would report a false invalid flag or a wrong sampler pointer. It changes the index, bank, mode and limits right after start. It also injects stray start and response pulses while a lookup is busy. A design that did not capture its context, or did not guard its state, would issue a wrong address, a second request, or an early or doubled done pulse.

// File: rtl/tbr_pkg.sv
package tbr_pkg;
  localparam int unsigned TBR_IDX_W  = 13;
  localparam int unsigned TBR_BANK_W = 5;
  localparam int unsigned TBR_DATA_W = 32;
  localparam int unsigned TBR_HDR_W  = 20;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2,
    ST_DONE = 2'd3
  } tbr_state_e;
endpackage

// File: rtl/tbr_capture.sv
module tbr_capture #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/tbr_ctrl.sv
module tbr_ctrl
  import tbr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       req_ready_i,
  input  logic       rsp_valid_i,
  output logic       start_acc,
  output logic       rsp_acc,
  output logic       req_valid_o,
  output logic       done_o
);
  tbr_state_e state_q, state_d;

  // Events exported to the top for capture enables and checking.
  assign start_acc   = (state_q == ST_IDLE) && start_i;
  assign rsp_acc     = (state_q == ST_WAIT) && rsp_valid_i;
  assign req_valid_o = (state_q == ST_REQ);
  assign done_o      = (state_q == ST_DONE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i)     state_d = ST_REQ;
      ST_REQ:  if (req_ready_i) state_d = ST_WAIT;
      ST_WAIT: if (rsp_valid_i) state_d = ST_DONE;
      ST_DONE:                  state_d = ST_IDLE;
      default:                  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/tbr_decode.sv
module tbr_decode #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned HDR_W  = 20
) (
  input  logic [DATA_W-1:0] word_i,
  input  logic              alias_i,
  input  logic [HDR_W-1:0]  lim_hdr_i,
  input  logic [HDR_W-1:0]  lim_smp_i,
  output logic [HDR_W-1:0]  hdr_o,
  output logic [HDR_W-1:0]  smp_o,
  output logic              inv_o
);
  localparam int unsigned SMP_W = DATA_W - HDR_W;

  function automatic logic [HDR_W-1:0] low_field(input logic [DATA_W-1:0] w);
    return w[HDR_W-1:0];
  endfunction

  function automatic logic [HDR_W-1:0] high_field(input logic [DATA_W-1:0] w);
    logic [HDR_W-1:0] r;
    r = '0;
    r[SMP_W-1:0] = w[DATA_W-1:HDR_W];
    return r;
  endfunction

  function automatic logic beyond(input logic [HDR_W-1:0] p,
                                  input logic [HDR_W-1:0] lim);
    return p > lim;
  endfunction

  logic [HDR_W-1:0] hdr_w, raw_smp_w;

  assign hdr_w     = low_field(word_i);
  assign raw_smp_w = high_field(word_i);
  assign hdr_o     = hdr_w;
  assign smp_o     = alias_i ? hdr_w : raw_smp_w;
  assign inv_o     = beyond(hdr_w, lim_hdr_i) || beyond(smp_o, lim_smp_i);
endmodule

// File: rtl/tex_bind_resolver.sv
module tex_bind_resolver
  import tbr_pkg::*;
#(
  parameter int unsigned IDX_W  = TBR_IDX_W,
  parameter int unsigned BANK_W = TBR_BANK_W,
  parameter int unsigned DATA_W = TBR_DATA_W,
  parameter int unsigned HDR_W  = TBR_HDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [IDX_W-1:0]  index_i,
  input  logic [BANK_W-1:0] bank_sel_i,
  input  logic              hdr_bind_mode_i,
  input  logic [HDR_W-1:0]  max_hdr_idx_i,
  input  logic [HDR_W-1:0]  max_smp_idx_i,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic [BANK_W-1:0] req_bank_o,
  output logic [IDX_W-1:0]  req_addr_o,
  input  logic              rsp_valid_i,
  input  logic [DATA_W-1:0] rsp_data_i,
  output logic              done_o,
  output logic [HDR_W-1:0]  hdr_ptr_o,
  output logic [HDR_W-1:0]  smp_ptr_o,
  output logic              invalid_o
);
  localparam int unsigned CTX_W = IDX_W + BANK_W + 1 + 2 * HDR_W;
  localparam int unsigned RES_W = 2 * HDR_W + 1;

  logic             start_acc, rsp_acc;
  logic [CTX_W-1:0] ctx_d, ctx_q;
  logic [RES_W-1:0] res_d, res_q;

  logic [IDX_W-1:0]  ctx_idx;
  logic [BANK_W-1:0] ctx_bank;
  logic              ctx_mode;
  logic [HDR_W-1:0]  ctx_lim_hdr, ctx_lim_smp;
  logic [HDR_W-1:0]  dec_hdr, dec_smp;
  logic              dec_inv;

  tbr_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .req_ready_i (req_ready_i),
    .rsp_valid_i (rsp_valid_i),
    .start_acc   (start_acc),
    .rsp_acc     (rsp_acc),
    .req_valid_o (req_valid_o),
    .done_o      (done_o)
  );

  assign ctx_d = {index_i, bank_sel_i, hdr_bind_mode_i, max_hdr_idx_i, max_smp_idx_i};

  tbr_capture #(.W(CTX_W)) u_ctx (
    .clk (clk), .rst_n (rst_n), .en (start_acc), .d (ctx_d), .q (ctx_q)
  );

  assign {ctx_idx, ctx_bank, ctx_mode, ctx_lim_hdr, ctx_lim_smp} = ctx_q;
  assign req_addr_o = ctx_idx;
  assign req_bank_o = ctx_bank;

  tbr_decode #(.DATA_W(DATA_W), .HDR_W(HDR_W)) u_dec (
    .word_i    (rsp_data_i),
    .alias_i   (ctx_mode),
    .lim_hdr_i (ctx_lim_hdr),
    .lim_smp_i (ctx_lim_smp),
    .hdr_o     (dec_hdr),
    .smp_o     (dec_smp),
    .inv_o     (dec_inv)
  );

  assign res_d = {dec_hdr, dec_smp, dec_inv};

  tbr_capture #(.W(RES_W)) u_res (
    .clk (clk), .rst_n (rst_n), .en (rsp_acc), .d (res_d), .q (res_q)
  );

  assign {hdr_ptr_o, smp_ptr_o, invalid_o} = res_q;
endmodule

// File: rtl/tbr_checker.sv
module tbr_checker #(
  parameter int unsigned IDX_W  = 13,
  parameter int unsigned BANK_W = 5,
  parameter int unsigned HDR_W  = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid_o,
  input logic              req_ready_i,
  input logic [BANK_W-1:0] req_bank_o,
  input logic [IDX_W-1:0]  req_addr_o,
  input logic              done_o,
  input logic [HDR_W-1:0]  hdr_ptr_o,
  input logic [HDR_W-1:0]  smp_ptr_o,
  input logic              invalid_o,
  input logic              ctx_mode,
  input logic [HDR_W-1:0]  ctx_lim_hdr,
  input logic [HDR_W-1:0]  ctx_lim_smp,
  input logic              rsp_acc
);
  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(req_addr_o) && $stable(req_bank_o)));

  p_req_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && req_ready_i) |=> !req_valid_o);

  p_alias_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && ctx_mode) |-> (smp_ptr_o == hdr_ptr_o));

  p_limit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (invalid_o == ((hdr_ptr_o > ctx_lim_hdr) || (smp_ptr_o > ctx_lim_smp))));

  p_done_after_rsp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_acc |=> done_o);

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_no_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !req_valid_o);

  p_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && req_valid_o));
endmodule

bind tex_bind_resolver tbr_checker #(
  .IDX_W (IDX_W), .BANK_W (BANK_W), .HDR_W (HDR_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid_o (req_valid_o),
  .req_ready_i (req_ready_i),
  .req_bank_o  (req_bank_o),
  .req_addr_o  (req_addr_o),
  .done_o      (done_o),
  .hdr_ptr_o   (hdr_ptr_o),
  .smp_ptr_o   (smp_ptr_o),
  .invalid_o   (invalid_o),
  .ctx_mode    (ctx_mode),
  .ctx_lim_hdr (ctx_lim_hdr),
  .ctx_lim_smp (ctx_lim_smp),
  .rsp_acc     (rsp_acc)
);

// File: tb/tex_bind_resolver_tb_top.sv
`timescale 1ns/1ps
module tex_bind_resolver_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [12:0] index_i = '0;
  logic [4:0]  bank_sel_i = '0;
  logic        hdr_bind_mode_i = 1'b0;
  logic [19:0] max_hdr_idx_i = '0;
  logic [19:0] max_smp_idx_i = '0;
  logic        req_valid_o;
  logic        req_ready_i = 1'b0;
  logic [4:0]  req_bank_o;
  logic [12:0] req_addr_o;
  logic        rsp_valid_i = 1'b0;
  logic [31:0] rsp_data_i = '0;
  logic        done_o;
  logic [19:0] hdr_ptr_o, smp_ptr_o;
  logic        invalid_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  tex_bind_resolver dut_i (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Bench model of the pointer rules, written independently.
  function automatic logic [19:0] exp_smp(input logic [31:0] w, input bit alias_mode);
    logic [19:0] s;
    s = {8'h00, w[31:20]};
    if (alias_mode) s = w[19:0];
    return s;
  endfunction

  function automatic bit exp_inv(input logic [31:0] w, input bit alias_mode,
                                 input logic [19:0] mh, input logic [19:0] ms);
    int unsigned h, s;
    h = int'(w[19:0]);
    s = int'(exp_smp(w, alias_mode));
    return (h > int'(mh)) || (s > int'(ms));
  endfunction

  task automatic lookup(input logic [12:0] idx, input logic [4:0] bank, input bit md,
                        input logic [19:0] mh, input logic [19:0] ms,
                        input logic [31:0] word, input int rdy_d, input int rsp_d);
    logic [19:0] eh, es;
    bit ei;
    eh = word[19:0];
    es = exp_smp(word, md);
    ei = exp_inv(word, md, mh, ms);
    @(negedge clk);
    start_i = 1'b1; index_i = idx; bank_sel_i = bank; hdr_bind_mode_i = md;
    max_hdr_idx_i = mh; max_smp_idx_i = ms;
    @(negedge clk);
    // R8: disturb every captured input right after the start
    start_i = 1'b0; index_i = 13'($urandom); bank_sel_i = 5'($urandom);
    hdr_bind_mode_i = ~md; max_hdr_idx_i = 20'($urandom); max_smp_idx_i = 20'($urandom);
    chk(req_valid_o == 1'b1, "R2", "req_valid", 32'(req_valid_o), 1);
    chk(req_addr_o == idx, "R2", "req_addr", 32'(req_addr_o), 32'(idx));
    chk(req_bank_o == bank, "R2", "req_bank", 32'(req_bank_o), 32'(bank));
    for (int i = 0; i < rdy_d; i++) begin
      if (i == 0) begin start_i = 1'b1; rsp_valid_i = 1'b1; rsp_data_i = $urandom; end
      @(negedge clk);
      start_i = 1'b0; rsp_valid_i = 1'b0;
      chk(req_valid_o && req_addr_o == idx && req_bank_o == bank, "R2", "held request",
          32'(req_addr_o), 32'(idx));
      chk(done_o == 1'b0, "R7", "stray rsp/start in request phase", 32'(done_o), 0);
    end
    req_ready_i = 1'b1;
    @(negedge clk);
    req_ready_i = 1'b0;
    chk(req_valid_o == 1'b0, "R2", "request dropped", 32'(req_valid_o), 0);
    for (int i = 0; i < rsp_d; i++) begin
      if (i == 0) start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk(done_o == 1'b0 && req_valid_o == 1'b0, "R7", "busy while waiting",
          {30'd0, done_o, req_valid_o}, 0);
    end
    rsp_valid_i = 1'b1; rsp_data_i = word;
    @(negedge clk);
    rsp_valid_i = 1'b0; rsp_data_i = $urandom; start_i = 1'b1;
    chk(done_o == 1'b1, "R6", "done pulse", 32'(done_o), 1);
    chk(hdr_ptr_o == eh, "R3", "header pointer", 32'(hdr_ptr_o), 32'(eh));
    chk(smp_ptr_o == es, md ? "R4" : "R3", "sampler pointer", 32'(smp_ptr_o), 32'(es));
    chk(invalid_o == ei, "R5", "invalid flag", 32'(invalid_o), 32'(ei));
    @(negedge clk);
    start_i = 1'b0;
    chk(done_o == 1'b0, "R6", "done single cycle", 32'(done_o), 0);
    chk(req_valid_o == 1'b0, "R7", "start in done cycle ignored", 32'(req_valid_o), 0);
    chk(hdr_ptr_o == eh && smp_ptr_o == es && invalid_o == ei, "R6", "result held",
        32'(hdr_ptr_o), 32'(eh));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(req_valid_o == 0 && done_o == 0 && invalid_o == 0 && hdr_ptr_o == 0 && smp_ptr_o == 0,
        "R1", "reset state", {req_valid_o, done_o, invalid_o, hdr_ptr_o[0], smp_ptr_o[0]}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_valid_o == 0 && done_o == 0, "R1", "idle after reset", 32'(req_valid_o), 0);

    // R5 boundaries: pointer equal to limit is valid, one above is invalid
    lookup(13'h0001, 5'd3, 1'b0, 20'h00100, 20'h00055, {12'h055, 20'h00100}, 0, 0);
    lookup(13'h1FFF, 5'd31, 1'b0, 20'h000FF, 20'h00FFF, {12'h010, 20'h00100}, 1, 2);
    lookup(13'h0AAA, 5'd0, 1'b0, 20'hFFFFF, 20'h00054, {12'h055, 20'h00001}, 2, 1);
    // R4: upper field huge but ignored in header-binding mode
    lookup(13'h0123, 5'd7, 1'b1, 20'h00200, 20'h00200, {12'hFFF, 20'h00200}, 3, 0);
    lookup(13'h0124, 5'd8, 1'b1, 20'hFFFFF, 20'h001FF, {12'h000, 20'h00200}, 0, 3);
    // R3: all-ones word with maximal limits
    lookup(13'h0000, 5'd1, 1'b0, 20'hFFFFF, 20'hFFFFF, 32'hFFFF_FFFF, 1, 1);

    for (int n = 0; n < 60; n++) begin
      logic [31:0] w;
      logic [19:0] mh, ms;
      w  = $urandom;
      mh = ($urandom % 2) ? w[19:0] + 20'($urandom % 3) - 20'd1 : 20'($urandom);
      ms = ($urandom % 2) ? {8'h00, w[31:20]} : 20'($urandom % 4096);
      lookup(13'($urandom), 5'($urandom), bit'($urandom % 2), mh, ms, w,
             int'($urandom % 4), int'($urandom % 5));
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule